// File: doc/BRIEF.md
# I2C Slave Conversion Result Reader

This block sits between a data converter and a two-wire serial bus and lets a bus master fetch the newest 16-bit conversion result. It oversamples the bus clock and data lines on the system clock. It detects start and stop conditions and receives an address byte made of seven address bits followed by a direction bit. When the address matches, it acknowledges. On a read it returns the held result as two bytes, high byte first and most significant bit first. The data line is open-drain, so the block only ever asserts a pull-low enable and never drives the line high.

One strap input selects between two fixed slave addresses. The converter side hands over a new result with a one-cycle valid strobe. The block takes the result at once when no read is under way. A result that arrives during a read is parked and applied once the transfer ends, so the two bytes of one read always belong to the same conversion.

Top module: `i2c_result_reader`

## Requirements
- R1: With `addr_sel_i` low the slave answers address 7'b0010100, and with it high the slave answers 7'b1010100. The address byte carries the address in bits 7..1 and the direction in bit 0, where 1 means read. On a match the block pulls SDA low during the ninth SCL clock.
- R2: An address byte that does not match is not acknowledged. SDA stays released for the rest of that transaction, so any bits the master clocks in read as 1.
- R3: The only bus output is a pull-low enable (1 = pull SDA low). It changes only while SCL is low.
- R4: A read returns the held result over 16 SCL clocks, bit 15 first. Bits 15..8 come out before the master's acknowledge and bits 7..0 after it. Each bit is updated after an SCL falling edge and is stable while SCL is high.
- R5: If the master answers the first data byte with a NACK (SDA high), the block releases SDA and sends no second byte.
- R6: A `result_valid_i` pulse while `busy_o` is low loads `result_i` as the held result. A later read returns the most recently loaded value.
- R7: A `result_valid_i` pulse while `busy_o` is high leaves the current read unchanged. The value is applied after the transfer ends, and the next read returns it.
- R8: A start condition (SDA falling while SCL is high) or a stop condition (SDA rising while SCL is high) at any point ends the current transfer and releases SDA. After a repeated start, a new address byte is decoded normally.
- R9: A write-direction address byte that matches is acknowledged. The data bytes that follow are not acknowledged and leave SDA released.
- R10: `busy_o` rises when a read address is acknowledged and falls at the next start or stop condition. It stays low for write accesses.
- R11: After reset SDA is released, `busy_o` is low and the held result is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 16 times the SCL rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen on the pad |
| sda_i | input | 1 | Bus data line as seen on the pad |
| addr_sel_i | input | 1 | Strap that selects one of the two slave addresses |
| result_i | input | 16 | Conversion result from the converter |
| result_valid_i | input | 1 | One-cycle strobe marking `result_i` as new |
| sda_pull_o | output | 1 | 1 pulls SDA low, 0 releases it |
| busy_o | output | 1 | A read transfer is in progress |

## Verification
The bench targets the following corner cases:
- A result that arrives in the middle of a read. A design that updates immediately would return a high byte and a low byte from two different conversions, or would drop the new value.
- A NACK after the first byte. A design that ignores it would keep pulling SDA for the low byte and could block a stop condition.
- A stop inside the address byte and a repeated start after a write. A wrong abort path would leave the block stuck, with SDA held or the next address missed.
- Mismatched addresses, for both strap settings. A loose address compare would acknowledge another device's address.
- Write accesses. A design that treated them like reads would acknowledge or drive the data bytes that follow.

// File: rtl/i2c_rr_pkg.sv
package i2c_rr_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_AACK,
    ST_TX,
    ST_TACK,
    ST_SKIP
  } rr_state_t;

  localparam int BYTE_W = 8;

endpackage

// File: rtl/rr_sync_edge.sv
module rr_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic lvl_o,
  output logic rise_o,
  output logic fall_o
);

  logic [STAGES-1:0] pipe_q;
  logic              prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pipe_q <= '1;
      prev_q <= 1'b1;
    end else begin
      pipe_q <= {pipe_q[STAGES-2:0], d_i};
      prev_q <= pipe_q[STAGES-1];
    end
  end

  assign lvl_o  = pipe_q[STAGES-1];
  assign rise_o = lvl_o & ~prev_q;
  assign fall_o = ~lvl_o & prev_q;

endmodule

// File: rtl/rr_result_hold.sv
module rr_result_hold #(
  parameter int RES_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             busy_i,
  input  logic             valid_i,
  input  logic [RES_W-1:0] data_i,
  output logic [RES_W-1:0] result_o
);

  logic [RES_W-1:0] res_q, res_d, pend_q, pend_d;
  logic             pv_q, pv_d;

  always_comb begin
    res_d  = res_q;
    pend_d = pend_q;
    pv_d   = pv_q;
    if (valid_i) begin
      if (busy_i) begin
        pend_d = data_i;
        pv_d   = 1'b1;
      end else begin
        res_d = data_i;
        pv_d  = 1'b0;
      end
    end else if (!busy_i && pv_q) begin
      res_d = pend_q;
      pv_d  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q  <= '0;
      pend_q <= '0;
      pv_q   <= 1'b0;
    end else begin
      res_q  <= res_d;
      pend_q <= pend_d;
      pv_q   <= pv_d;
    end
  end

  assign result_o = res_q;

  AST_HOLD_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    $past(busy_i) |-> $stable(res_q)); // R7

  AST_PEND_APPLIED: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_i && pv_q && !valid_i) |=> (res_q == $past(pend_q))); // R7

endmodule

// File: rtl/rr_bus_fsm.sv
module rr_bus_fsm
  import i2c_rr_pkg::*;
#(
  parameter int         RES_W   = 16,
  parameter logic [6:0] ADDR_LO = 7'h14,
  parameter logic [6:0] ADDR_HI = 7'h54
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_rise_i,
  input  logic             scl_fall_i,
  input  logic             sda_lvl_i,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic             strap_i,
  input  logic [RES_W-1:0] result_i,
  output logic             sda_pull_o,
  output logic             busy_o
);

  localparam int NBYTES = RES_W / BYTE_W;
  localparam int BIDX_W = (NBYTES > 1) ? $clog2(NBYTES) : 1;
  localparam int CNT_W  = $clog2(BYTE_W) + 1;

  rr_state_t         st_q, st_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [BYTE_W-1:0] sh_q, sh_d;
  logic [BIDX_W-1:0] bidx_q, bidx_d;
  logic              rw_q, rw_d, ack_q, ack_d, pull_q, pull_d, busy_q, busy_d;
  logic [6:0]        my_addr;

  function automatic logic [BYTE_W-1:0] pick(logic [RES_W-1:0] r, logic [BIDX_W-1:0] i);
    return r[BYTE_W*(NBYTES-1-int'(i)) +: BYTE_W];
  endfunction

  assign my_addr = strap_i ? ADDR_HI : ADDR_LO;

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    sh_d   = sh_q;
    bidx_d = bidx_q;
    rw_d   = rw_q;
    ack_d  = ack_q;
    pull_d = pull_q;
    busy_d = busy_q;
    if (stop_i) begin
      st_d   = ST_IDLE;
      pull_d = 1'b0;
      busy_d = 1'b0;
    end else if (start_i) begin
      st_d   = ST_ADDR;
      cnt_d  = '0;
      pull_d = 1'b0;
      busy_d = 1'b0;
    end else begin
      case (st_q)
        ST_ADDR: begin
          if (scl_rise_i) begin
            sh_d  = {sh_q[BYTE_W-2:0], sda_lvl_i};
            cnt_d = cnt_q + 1'b1;
          end else if (scl_fall_i && cnt_q == CNT_W'(BYTE_W)) begin
            if (sh_q[BYTE_W-1:1] == my_addr) begin
              st_d   = ST_AACK;
              pull_d = 1'b1;
              rw_d   = sh_q[0];
              busy_d = sh_q[0];
            end else begin
              st_d = ST_SKIP;
            end
          end
        end
        ST_AACK: begin
          if (scl_fall_i) begin
            if (rw_q) begin
              st_d   = ST_TX;
              bidx_d = '0;
              sh_d   = pick(result_i, '0);
              pull_d = ~sh_d[BYTE_W-1];
              cnt_d  = '0;
            end else begin
              st_d   = ST_SKIP;
              pull_d = 1'b0;
            end
          end
        end
        ST_TX: begin
          if (scl_fall_i) begin
            if (cnt_q == CNT_W'(BYTE_W - 1)) begin
              st_d   = ST_TACK;
              pull_d = 1'b0;
            end else begin
              sh_d   = {sh_q[BYTE_W-2:0], 1'b0};
              pull_d = ~sh_q[BYTE_W-2];
              cnt_d  = cnt_q + 1'b1;
            end
          end
        end
        ST_TACK: begin
          if (scl_rise_i) begin
            ack_d = ~sda_lvl_i;
          end else if (scl_fall_i) begin
            if (ack_q && bidx_q != BIDX_W'(NBYTES - 1)) begin
              st_d   = ST_TX;
              bidx_d = bidx_q + 1'b1;
              sh_d   = pick(result_i, bidx_d);
              pull_d = ~sh_d[BYTE_W-1];
              cnt_d  = '0;
            end else begin
              st_d = ST_SKIP;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      sh_q   <= '0;
      bidx_q <= '0;
      rw_q   <= 1'b0;
      ack_q  <= 1'b0;
      pull_q <= 1'b0;
      busy_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      sh_q   <= sh_d;
      bidx_q <= bidx_d;
      rw_q   <= rw_d;
      ack_q  <= ack_d;
      pull_q <= pull_d;
      busy_q <= busy_d;
    end
  end

  assign sda_pull_o = pull_q;
  assign busy_o     = busy_q;

  AST_READ_ACKED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> sda_pull_o); // R10

endmodule

// File: rtl/i2c_result_reader.sv
module i2c_result_reader #(
  parameter int         RES_W       = 16,
  parameter int         SYNC_STAGES = 2,
  parameter logic [6:0] ADDR_LO     = 7'h14,
  parameter logic [6:0] ADDR_HI     = 7'h54
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_i,
  input  logic             sda_i,
  input  logic             addr_sel_i,
  input  logic [RES_W-1:0] result_i,
  input  logic             result_valid_i,
  output logic             sda_pull_o,
  output logic             busy_o
);

  logic [1:0]       rst_pipe_q;
  logic             rst_n_s;
  logic             scl_lvl, scl_rise, scl_fall;
  logic             sda_lvl, sda_rise, sda_fall;
  logic             start_det, stop_det;
  logic [RES_W-1:0] held;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_n_s = rst_pipe_q[1];

  rr_sync_edge #(.STAGES(SYNC_STAGES)) i_scl_sync (
    .clk(clk), .rst_n(rst_n_s), .d_i(scl_i),
    .lvl_o(scl_lvl), .rise_o(scl_rise), .fall_o(scl_fall)
  );

  rr_sync_edge #(.STAGES(SYNC_STAGES)) i_sda_sync (
    .clk(clk), .rst_n(rst_n_s), .d_i(sda_i),
    .lvl_o(sda_lvl), .rise_o(sda_rise), .fall_o(sda_fall)
  );

  assign start_det = sda_fall & scl_lvl;
  assign stop_det  = sda_rise & scl_lvl;

  rr_result_hold #(.RES_W(RES_W)) i_hold (
    .clk(clk), .rst_n(rst_n_s), .busy_i(busy_o),
    .valid_i(result_valid_i), .data_i(result_i), .result_o(held)
  );

  rr_bus_fsm #(.RES_W(RES_W), .ADDR_LO(ADDR_LO), .ADDR_HI(ADDR_HI)) i_fsm (
    .clk(clk), .rst_n(rst_n_s),
    .scl_rise_i(scl_rise), .scl_fall_i(scl_fall), .sda_lvl_i(sda_lvl),
    .start_i(start_det), .stop_i(stop_det), .strap_i(addr_sel_i),
    .result_i(held), .sda_pull_o(sda_pull_o), .busy_o(busy_o)
  );

  AST_PULL_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n_s)
    !$stable(sda_pull_o) |-> !scl_lvl); // R3

  AST_STOP_RELEASES: assert property (@(posedge clk) disable iff (!rst_n_s)
    stop_det |=> (!sda_pull_o && !busy_o)); // R8

endmodule

// File: tb/test_i2c_result_reader.sv
module test_i2c_result_reader;

  localparam int T = 20;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        scl_m = 1'b1, sda_m = 1'b1;
  logic        strap = 1'b0;
  logic [15:0] res_in = '0;
  logic        res_v = 1'b0;
  logic        sda_pull, busy;
  logic        sda_bus;
  int          n_chk = 0, n_fail = 0, pull_bad = 0;
  logic        pull_prev = 1'b0;
  bit          done = 1'b0;

  always #4 clk = ~clk;

  assign sda_bus = sda_m & ~sda_pull;

  i2c_result_reader i_i2c_result_reader (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
    .addr_sel_i(strap), .result_i(res_in), .result_valid_i(res_v),
    .sda_pull_o(sda_pull), .busy_o(busy)
  );

  always @(negedge clk) begin
    if (rst_n && sda_pull !== pull_prev && scl_m) pull_bad++;
    pull_prev = sda_pull;
  end

  function automatic logic [6:0] exp_addr(input logic s);
    return s ? 7'b1010100 : 7'b0010100;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wclk(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic bus_start();
    wclk(4); sda_m = 1'b1; wclk(T); scl_m = 1'b1; wclk(T);
    sda_m = 1'b0; wclk(T); scl_m = 1'b0;
  endtask

  task automatic bus_stop();
    wclk(4); sda_m = 1'b0; wclk(T); scl_m = 1'b1; wclk(T);
    sda_m = 1'b1; wclk(T);
  endtask

  task automatic put_bit(input logic b);
    wclk(4); sda_m = b; wclk(T); scl_m = 1'b1; wclk(T); scl_m = 1'b0;
  endtask

  task automatic get_bit(output logic b);
    wclk(4); sda_m = 1'b1; wclk(T); scl_m = 1'b1; wclk(T/2);
    @(negedge clk); b = sda_bus; wclk(T/2); scl_m = 1'b0;
  endtask

  task automatic put_byte(input logic [7:0] d, output logic ack_bit);
    for (int i = 7; i >= 0; i--) put_bit(d[i]);
    get_bit(ack_bit);
  endtask

  task automatic get_byte(output logic [7:0] d);
    for (int i = 7; i >= 0; i--) begin
      logic b;
      get_bit(b);
      d[i] = b;
    end
  endtask

  task automatic load(input logic [15:0] v);
    @(negedge clk); res_in = v; res_v = 1'b1;
    @(negedge clk); res_v = 1'b0;
  endtask

  task automatic do_read(input logic [6:0] a, output logic ack_bit, output logic [15:0] d);
    logic [7:0] hi, lo;
    bus_start();
    put_byte({a, 1'b1}, ack_bit);
    get_byte(hi); put_bit(1'b0);
    get_byte(lo); put_bit(1'b1);
    bus_stop();
    d = {hi, lo};
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic        ack;
    logic [15:0] d;
    logic [7:0]  b8;
    int          seed;
    seed = 32'h1ce5;
    void'($urandom(seed));
    wclk(3); rst_n = 1'b1; wclk(12);

    // R11 reset state
    @(negedge clk);
    check("R11 pull", sda_pull, 0);
    check("R11 busy", busy, 0);
    do_read(exp_addr(0), ack, d);
    check("R11 held zero", d, 16'h0000);

    // R1 R4 R6 R10 basic read, strap low
    load(16'hA53C);
    bus_start(); put_byte({exp_addr(0), 1'b1}, ack);
    check("R1 ack low strap", ack, 0);
    @(negedge clk); check("R10 busy after ack", busy, 1);
    get_byte(b8); check("R4 high byte", b8, 8'hA5); put_bit(1'b0);
    get_byte(b8); check("R4 low byte", b8, 8'h3C); put_bit(1'b1);
    bus_stop(); @(negedge clk); check("R10 busy after stop", busy, 0);

    // R1 strap high
    strap = 1'b1; load(16'h0F81);
    do_read(exp_addr(1), ack, d);
    check("R1 ack high strap", ack, 0); check("R6 data high strap", d, 16'h0F81);

    // R2 mismatch: low-strap address while strap high
    do_read(exp_addr(0), ack, d);
    check("R2 nack", ack, 1); check("R2 released", d, 16'hFFFF);

    // R5 NACK after first byte
    load(16'h1200);
    bus_start(); put_byte({exp_addr(1), 1'b1}, ack);
    get_byte(b8); check("R5 first byte", b8, 8'h12); put_bit(1'b1);
    get_byte(b8); check("R5 no second byte", b8, 8'hFF);
    bus_stop();

    // R7 update during read
    load(16'h3355);
    bus_start(); put_byte({exp_addr(1), 1'b1}, ack);
    get_byte(b8); put_bit(1'b0);
    load(16'hC0DE);
    get_byte(b8); check("R7 low byte unchanged", b8, 8'h55); put_bit(1'b1);
    bus_stop();
    do_read(exp_addr(1), ack, d);
    check("R7 deferred value", d, 16'hC0DE);

    // R9 write access
    bus_start(); put_byte({exp_addr(1), 1'b0}, ack);
    check("R9 write ack", ack, 0);
    @(negedge clk); check("R10 no busy on write", busy, 0);
    put_byte(8'h00, ack); check("R9 data not acked", ack, 1);

    // R8 repeated start after write, then read
    bus_start(); put_byte({exp_addr(1), 1'b1}, ack);
    get_byte(b8); put_bit(1'b0);
    get_byte(b8); put_bit(1'b1);
    check("R8 read after repeated start", {ack, b8}, {1'b0, 8'hDE});
    bus_stop();

    // R8 stop inside address byte
    bus_start();
    for (int i = 7; i >= 4; i--) put_bit(exp_addr(1)[i-1]);
    bus_stop(); @(negedge clk);
    check("R8 abort released", {sda_pull, busy}, 2'b00);
    do_read(exp_addr(1), ack, d);
    check("R8 recovery read", d, 16'hC0DE);

    // R1 R2 R4 R6 random reads
    for (int k = 0; k < 16; k++) begin
      logic [15:0] v;
      logic        s, bad;
      v = 16'($urandom); s = 1'($urandom); bad = ($urandom % 4) == 0;
      strap = s; load(v);
      do_read(exp_addr(s ^ bad), ack, d);
      check("R1 random ack", ack, bad);
      check("R4 R6 random data", d, bad ? 16'hFFFF : v);
    end

    check("R3 pull changed with SCL high", pull_bad, 0);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule